// File: doc/BRIEF.md
# Zero-Voltage-Switching Full-Bridge Gate Sequencer

This block produces the four gate-drive enables of a zero-voltage-switching full bridge from a digital sawtooth. A cycle counter stands in for the timing capacitor. Each half-cycle is a ramp interval followed by a deadtime interval, and the lengths of both are programmable in clock cycles. The two high-side legs take turns at a fixed 50% share. Each swap happens inside the deadtime, a programmable number of cycles ahead of the next ramp, which leaves room for the resonant transition of the bridge node.

Only the low-side legs are modulated. In each half-cycle, one low-side leg turns on at the start of the ramp. It turns off when the ramp count reaches the duty command or when a terminate request arrives, whichever comes first. The active low-side leg is always the one diagonal to the high-side leg that is on. A steering rule makes the delivered pulses alternate between left and right even when a half-cycle produces no pulse. A fault input blanks all four drives while the sequencing keeps running underneath.

Top module: `zvs_bridge_seq`

## Requirements
- R1: A half-cycle has `max(ramp_len,1)` ramp cycles followed by `max(dead_len,1)` deadtime cycles. Half-cycles run back to back, so one full bridge cycle covers two of them.
- R2: Once running, exactly one of `hs_left`/`hs_right` is high in every cycle without a fault. The selection holds through every ramp cycle and changes only during the deadtime or at a half-cycle boundary.
- R3: Let `FS = 2**LEAD_W` and `lead = floor(min(lead_code,FS) * D / FS)`, where `D` is the effective deadtime. `lead` is clamped to at most `D-1`. The high-side swap first shows in deadtime cycle index `D-lead`, counted from 0. With `lead = 0` it shows at the first ramp cycle of the next half-cycle.
- R4: In ramp cycle index `c` (from 0), the active low-side leg is high exactly when `c < duty_cmd`, unless that half-cycle is suppressed or terminated. Low-side legs are low in every deadtime cycle.
- R5: If `term_req` is high at a clock edge that ends a ramp cycle, the low-side leg is low from the next cycle until the half-cycle ends. It is re-armed at the next half-cycle.
- R6: `ls_right` may be high only while `hs_left` is high, and `ls_left` only while `hs_right` is high. After the start-up half-cycle, halves alternate left-high/right-low and right-high/left-low.
- R7: With `duty_cmd == 0`, both low-side legs stay low for that half-cycle while the high-side legs keep alternating.
- R8: A half-cycle whose side equals the side of the most recent half-cycle that produced a pulse is suppressed. As a result, delivered pulses strictly alternate sides. A half-cycle counts as having produced a pulse even if `fault` masked its output.
- R9: While `fault` is high, all four outputs are low. The counters and the side sequence keep advancing, and drive resumes on the cycle after `fault` falls.
- R10: `ramp_len`, `dead_len`, `duty_cmd` and `lead_code` are captured only at the edge that starts a half-cycle. Changes made during a half-cycle have no effect until the next one.
- R11: In reset, and in the one cycle after reset is released, all outputs are low. The first half-cycle then starts with `hs_left` and `ls_right` as the active pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ramp_len | input | CNT_W | Ramp interval in cycles (0 treated as 1) |
| dead_len | input | CNT_W | Deadtime interval in cycles (0 treated as 1) |
| duty_cmd | input | CNT_W | Low-side on-time in ramp cycles |
| lead_code | input | LEAD_W+1 | High-side lead as a fraction of full scale 2**LEAD_W |
| term_req | input | 1 | Ends the current low-side pulse |
| fault | input | 1 | Forces all outputs low while high |
| hs_left | output | 1 | Upper-left gate enable |
| hs_right | output | 1 | Upper-right gate enable |
| ls_left | output | 1 | Lower-left gate enable |
| ls_right | output | 1 | Lower-right gate enable |

## Verification
Every output is a combinational decode of registered state. A setting captured at a half-cycle-starting edge therefore shows in the very next cycle. A terminate request shows one cycle after the edge that samples it, and a fault takes effect in the same cycle it is driven. The bench changes inputs 2 ns after a rising edge and samples 2 ns after the following edge. Because it walks each half-cycle cycle by cycle, it can compare every ramp and deadtime cycle against an index-based expectation: `c < duty_cmd` for the low side, and `D - lead` for the high-side swap point.

// File: rtl/zvs_seq_pkg.sv
// Shared types for the bridge gate sequencer.
package zvs_seq_pkg;
    // Oscillator phase: ramp (charge) or deadtime (discharge).
    typedef enum logic {
        PH_RAMP = 1'b0,
        PH_DEAD = 1'b1
    } phase_t;
endpackage

// File: rtl/zvs_osc.sv
// Counter oscillator. It walks a ramp interval, then a deadtime interval.
// Each setting is captured at the edge that starts a half-cycle. The
// module flags the last deadtime cycle and the cycle whose closing edge
// swaps the high-side legs.
// Assumes: the settings are stable around the half-start edge.
module zvs_osc
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  ramp_len,
    input  logic [CNT_W-1:0]  dead_len,
    input  logic [CNT_W-1:0]  duty_cmd,
    input  logic [LEAD_W:0]   lead_code,
    output phase_t            phase,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  duty_sh,
    output logic              half_start,
    output logic              swap_now
);
    localparam int PW = CNT_W + LEAD_W + 1;
    localparam logic [LEAD_W:0] FULL = (LEAD_W+1)'(1 << LEAD_W);

    logic [CNT_W-1:0]  ramp_sh, dead_sh, lead_sh;
    logic [CNT_W-1:0]  ramp_c, dead_c, lead_raw, lead_c;
    logic [LEAD_W:0]   code_c;
    logic [PW-1:0]     prod;

    // Clamp the incoming settings and scale the lead code by the deadtime.
    always_comb begin
        ramp_c   = (ramp_len == '0) ? CNT_W'(1) : ramp_len;
        dead_c   = (dead_len == '0) ? CNT_W'(1) : dead_len;
        code_c   = (lead_code > FULL) ? FULL : lead_code;
        prod     = PW'(code_c) * PW'(dead_c);
        lead_raw = CNT_W'(prod >> LEAD_W);
        lead_c   = (lead_raw >= dead_c) ? (dead_c - CNT_W'(1)) : lead_raw;
    end

    // Flags for the final deadtime cycle and for the high-side swap cycle.
    always_comb begin
        half_start = (phase == PH_DEAD) && (cnt == dead_sh - CNT_W'(1));
        swap_now   = (phase == PH_DEAD) &&
                     (cnt == dead_sh - CNT_W'(1) - lead_sh);
    end

    // Phase and count; the shadow settings load at each half-cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_DEAD;
            cnt     <= '0;
            ramp_sh <= CNT_W'(1);
            dead_sh <= CNT_W'(1);
            lead_sh <= '0;
            duty_sh <= '0;
        end else if (phase == PH_RAMP) begin
            if (cnt == ramp_sh - CNT_W'(1)) begin
                phase <= PH_DEAD;
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else if (half_start) begin
            phase   <= PH_RAMP;
            cnt     <= '0;
            ramp_sh <= ramp_c;
            dead_sh <= dead_c;
            lead_sh <= lead_c;
            duty_sh <= duty_cmd;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R1: the count stays inside the captured ramp length.
    p_ramp_cnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RAMP) |-> (cnt < ramp_sh));
    // R3: the swap point never falls after the half-cycle boundary.
    p_lead_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD) |-> (lead_sh < dead_sh));
endmodule

// File: rtl/zvs_high_side.sv
// High-side selector. It holds which upper leg is on and swaps that leg
// at the edge the oscillator marks. It enables the drive from the first
// half-cycle after reset onward.
// Assumes: swap_now is asserted only in deadtime cycles.
module zvs_high_side
    import zvs_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   half_start,
    input  logic   swap_now,
    output logic   hs_sel,
    output logic   hs_en
);
    // Swap the selected leg; enable once the first half-cycle begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_sel <= 1'b1;
            hs_en  <= 1'b0;
        end else begin
            if (swap_now)   hs_sel <= ~hs_sel;
            if (half_start) hs_en  <= 1'b1;
        end
    end

    // R2: the selection holds across each ramp cycle.
    p_hold_in_ramp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RAMP) |=> $stable(hs_sel));
    // R2: a change of selection always follows a deadtime cycle.
    p_swap_in_dead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_sel != $past(hs_sel)) |-> ($past(phase) == PH_DEAD));
endmodule

// File: rtl/zvs_low_side.sv
// Low-side modulator. It builds the trailing-edge pulse from the ramp
// count and the captured duty, latches terminate requests, and tracks
// the side of the last delivered pulse, so that a half-cycle on the same
// side is suppressed.
// Assumes: half_start is high only in the last deadtime cycle.
module zvs_low_side
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_sh,
    input  logic             half_start,
    input  logic             term_req,
    output logic             pulse,
    output logic             side
);
    logic term_q, fired_q, last_side, have_last, sup_q;
    logic last_nx, have_nx;

    // The pulse is high from the ramp start until duty, terminate or suppress.
    always_comb begin
        pulse = (phase == PH_RAMP) && (cnt < duty_sh) && !term_q && !sup_q;
    end

    // Record of the last fired side, as it will stand after a boundary.
    always_comb begin
        last_nx = fired_q ? side : last_side;
        have_nx = fired_q | have_last;
    end

    // Per-half pulse state and alternation bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side      <= 1'b1;
            term_q    <= 1'b0;
            fired_q   <= 1'b0;
            last_side <= 1'b0;
            have_last <= 1'b0;
            sup_q     <= 1'b0;
        end else if (half_start) begin
            side      <= ~side;
            term_q    <= 1'b0;
            fired_q   <= 1'b0;
            last_side <= last_nx;
            have_last <= have_nx;
            sup_q     <= have_nx && (last_nx == ~side);
        end else begin
            if ((phase == PH_RAMP) && term_req) term_q  <= 1'b1;
            if (pulse)                          fired_q <= 1'b1;
        end
    end

    // R8: a pulse that fired never repeats the side of the previous one.
    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (half_start && fired_q && have_last) |-> (last_side != side));
    // R5: after a terminate request in a ramp cycle, the pulse stays off.
    p_term_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_RAMP) && term_req) |=> !pulse);
endmodule

// File: rtl/zvs_bridge_seq.sv
// Top of the bridge gate sequencer. It wires the oscillator, the
// high-side selector and the low-side modulator, pairs each low-side leg
// with the diagonal high-side leg, and applies the fault blanking.
// Assumes: all inputs are synchronous to clk.
module zvs_bridge_seq
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  ramp_len,
    input  logic [CNT_W-1:0]  dead_len,
    input  logic [CNT_W-1:0]  duty_cmd,
    input  logic [LEAD_W:0]   lead_code,
    input  logic              term_req,
    input  logic              fault,
    output logic              hs_left,
    output logic              hs_right,
    output logic              ls_left,
    output logic              ls_right
);
    phase_t            phase;
    logic [CNT_W-1:0]  cnt, duty_sh;
    logic              half_start, swap_now;
    logic              hs_sel, hs_en, pulse, side;

    zvs_osc #(.CNT_W(CNT_W), .LEAD_W(LEAD_W)) u_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ramp_len   (ramp_len),
        .dead_len   (dead_len),
        .duty_cmd   (duty_cmd),
        .lead_code  (lead_code),
        .phase      (phase),
        .cnt        (cnt),
        .duty_sh    (duty_sh),
        .half_start (half_start),
        .swap_now   (swap_now)
    );

    zvs_high_side u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .half_start (half_start),
        .swap_now   (swap_now),
        .hs_sel     (hs_sel),
        .hs_en      (hs_en)
    );

    zvs_low_side #(.CNT_W(CNT_W)) u_ls (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .cnt        (cnt),
        .duty_sh    (duty_sh),
        .half_start (half_start),
        .term_req   (term_req),
        .pulse      (pulse),
        .side       (side)
    );

    // Decode the drive pairs: select 0 gives high-left with low-right.
    always_comb begin
        hs_left  = hs_en && !fault && !hs_sel;
        hs_right = hs_en && !fault &&  hs_sel;
        ls_right = pulse && !fault && !side;
        ls_left  = pulse && !fault &&  side;
    end

    // R6: during every ramp the high-side selection matches the pulse side.
    p_diagonal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RAMP) |-> (hs_sel == side));
    // R9: a fault blanks all four drives.
    p_fault_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !(hs_left || hs_right || ls_left || ls_right));
    // R4: the low side is off for the whole deadtime.
    p_dead_low_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD) |-> !(ls_left || ls_right));
endmodule

// File: tb/sim_zvs_bridge_seq.sv
module sim_zvs_bridge_seq;
    localparam int CNT_W  = 8;
    localparam int LEAD_W = 3;
    localparam int FS     = 1 << LEAD_W;

    logic clk = 1'b0;
    logic rst_n;
    logic [CNT_W-1:0] ramp_len, dead_len, duty_cmd;
    logic [LEAD_W:0]  lead_code;
    logic term_req, fault;
    logic hs_left, hs_right, ls_left, ls_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit side_b = 0;
    bit last_side = 0;
    bit have_last = 0;

    always #5 clk = ~clk;

    zvs_bridge_seq #(.CNT_W(CNT_W), .LEAD_W(LEAD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ramp_len(ramp_len), .dead_len(dead_len),
        .duty_cmd(duty_cmd), .lead_code(lead_code), .term_req(term_req),
        .fault(fault), .hs_left(hs_left), .hs_right(hs_right),
        .ls_left(ls_left), .ls_right(ls_right)
    );

    // Compare the four drives, ordered {hs_left, hs_right, ls_left, ls_right}.
    task automatic check4(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {hs_left, hs_right, ls_left, ls_right};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t got %b expected %b", tag, $time, got, exp);
        end
    endtask

    // Run one half-cycle. Inputs are applied in the last deadtime cycle of
    // the previous half; the bench samples every following cycle.
    task automatic run_half(input int r, input int d, input int dt,
                            input int code, input int term_c,
                            input bit flt, input bit scramble,
                            input string tag);
        int re, de, cc, lead;
        bit fire, on, upl;
        logic [3:0] exp;
        ramp_len  = CNT_W'(r);
        dead_len  = CNT_W'(d);
        duty_cmd  = CNT_W'(dt);
        lead_code = (LEAD_W+1)'(code);
        fault     = flt;
        term_req  = 1'b0;
        re   = (r == 0) ? 1 : r;
        de   = (d == 0) ? 1 : d;
        cc   = (code > FS) ? FS : code;
        lead = (cc * de) / FS;
        if (lead > de - 1) lead = de - 1;
        fire = (dt > 0) && !(have_last && (last_side == side_b));
        for (int i = 0; i < re + de; i++) begin
            @(posedge clk);
            #2;
            if (i < re) begin
                on  = fire && (i < dt) && ((term_c < 0) || (i <= term_c));
                upl = (side_b == 1'b0);
            end else begin
                on  = 1'b0;
                upl = ((i - re) >= (de - lead)) ? (side_b == 1'b1)
                                                 : (side_b == 1'b0);
            end
            exp = {upl, !upl, on && side_b, on && !side_b};
            if (flt) exp = 4'b0000;
            check4(tag, exp);
            term_req = (i == term_c);
            if (scramble && i == 0) begin
                ramp_len  = 8'd7;
                dead_len  = 8'd5;
                duty_cmd  = 8'd200;
                lead_code = 4'd3;
            end
        end
        term_req = 1'b0;
        if (fire) begin
            last_side = side_b;
            have_last = 1'b1;
        end
        side_b = ~side_b;
    endtask

    initial begin
        int rl[4];
        int dl[3];
        int cl[4];
        int dts[5];
        rl = '{1, 2, 3, 5};
        dl = '{1, 2, 4};
        cl = '{0, 4, 8, 15};
        rst_n = 1'b0;
        ramp_len = '0; dead_len = '0; duty_cmd = '0; lead_code = '0;
        term_req = 1'b0; fault = 1'b0;
        // R11: outputs low in reset and in the cycle after release.
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #2;
            check4("R11 in reset", 4'b0000);
        end
        rst_n = 1'b1;
        #1;
        check4("R11 after release", 4'b0000);
        run_half(3, 2, 2, 4, -1, 0, 0, "R11 first half");
        // R1 R2 R3 R4 R6 R7 R8: sweep of lengths, duty and lead.
        foreach (rl[a]) foreach (dl[b]) foreach (cl[c]) begin
            dts = '{0, 1, rl[a] - 1, rl[a], rl[a] + 2};
            foreach (dts[k])
                run_half(rl[a], dl[b], dts[k], cl[c], -1, 0, 0,
                         "R1 R2 R3 R4 R6 R7 R8 sweep");
        end
        // R8: a skipped half followed by the same side is suppressed.
        run_half(4, 2, 2, 2, -1, 0, 0, "R8 fire");
        run_half(4, 2, 0, 2, -1, 0, 0, "R8 skip");
        run_half(4, 2, 2, 2, -1, 0, 0, "R8 suppressed");
        run_half(4, 2, 2, 2, -1, 0, 0, "R8 resume");
        run_half(4, 2, 3, 2, -1, 0, 0, "R8 next");
        // R5: terminate at the first ramp cycle and at a later one.
        run_half(5, 2, 5, 0, 0, 0, 0, "R5 early");
        run_half(5, 2, 5, 0, 3, 0, 0, "R5 late");
        run_half(5, 2, 5, 0, -1, 0, 0, "R5 rearmed");
        // R9: fault blanks everything; sequencing continues underneath.
        run_half(4, 3, 3, 4, -1, 1, 0, "R9 fault");
        run_half(4, 3, 3, 4, -1, 1, 0, "R9 fault");
        run_half(4, 3, 3, 4, -1, 0, 0, "R9 recovered");
        run_half(4, 3, 3, 4, -1, 0, 0, "R9 recovered");
        // R10: mid-half changes do not touch the running half.
        run_half(3, 3, 2, 0, -1, 0, 1, "R10 scrambled");
        run_half(3, 3, 2, 0, -1, 0, 1, "R10 scrambled");
        run_half(0, 0, 1, 8, -1, 0, 0, "R10 zero lengths");
        run_half(0, 0, 1, 8, -1, 0, 0, "R10 zero lengths");
        run_half(6, 4, 9, 8, -1, 0, 0, "R10 settle");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired got running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule